// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal and vertical scan timing for a pixel display. A pixel counter runs across each line and a line counter runs down each frame. Both are compared against programmed windows to produce horizontal and vertical sync pulses, a blanking flag and a display-enable flag. The current pixel and line positions are also exported so that downstream fetch logic can use them.

Software programs the block through a simple write port. Each timing register packs two 16-bit positions, and every position is stored as its value minus one. A control register sets the run bit, the immediate-update bit, the two sync polarities and a five-way power-saving mode. In each power-saving mode the video, the horizontal sync and the vertical sync are suppressed independently.

Timing writes normally go to a shadow copy. That copy is moved into the working set at the last pixel of the frame, so a frame is never drawn with mixed timings.

A three-state control machine sequences the block:
- ST_HALT: the counters are held at zero.
- ST_SCAN: the counters run with the working timings.
- ST_PEND: the counters run, and a deferred timing write waits for the frame end.

The transitions are:
- start: ST_HALT to ST_SCAN when the run bit is set. The shadow set is copied at this step.
- defer: ST_SCAN to ST_PEND on a timing write while the immediate-update bit is clear.
- commit: ST_PEND to ST_SCAN at the frame end. The shadow set is copied at this step.
- recommit: ST_PEND stays in ST_PEND at the frame end if a new deferred write lands in that same cycle. The copy still happens.
- stop: ST_SCAN or ST_PEND goes to ST_HALT when the run bit is clear.

Top module: `raster_timing_gen`

## Requirements
- R1: The write address selects the register. Address 0 is control: bit 0 run, bit 1 immediate update, bit 2 horizontal polarity, bit 3 vertical polarity, bits 6:4 mode. Addresses 1, 2 and 3 are horizontal active/total, blank and sync. Addresses 4, 5 and 6 are the vertical counterparts. In every timing register, bits 15:0 hold the start (or active count) minus one and bits 31:16 hold the end (or total) minus one. Writes to any other address have no effect on any output.
- R2: While scanning, the pixel counter steps by one each cycle and returns to 0 after it reaches the horizontal total field. The line counter steps by one at each pixel wrap and returns to 0 after it reaches the vertical total field.
- R3: Display-enable is 1 only while scanning with video on, the pixel is at or below the horizontal active field and the line is at or below the vertical active field.
- R4: Blank is 1 in any of these cases: the block is halted; video is off; the pixel is above the horizontal blank start field and at or below its end field; the line is in the matching vertical window.
- R5: A sync is asserted while its counter is above the sync start field and at or below the sync end field. With its polarity bit set, the asserted level is high; with the bit clear, it is low. When the sync is not asserted, the output sits at the opposite level.
- R6: The mode codes are:
  - 0: video on, both syncs on.
  - 1: video blanked, both syncs on.
  - 2: video blanked, horizontal sync only.
  - 3: video blanked, vertical sync only.
  - 4 to 7: video blanked, no syncs.
  A suppressed sync is held at its inactive level.
- R7: The DAC power-down output is 1 exactly when the mode suppresses either sync.
- R8: Reset leaves the block halted with counters at 0, blank at 1, display-enable at 0 and both syncs at their inactive level. Clearing the run bit returns both counters to 0 one cycle later and holds them there.
- R9: With the immediate-update bit clear, a timing write made while scanning takes effect on the first cycle of the next frame. That cycle follows the one in which both counters sit at their totals.
- R10: With the immediate-update bit set, a timing write takes effect in the cycle after the write.
- R11: Setting the run bit copies the shadow timings into the working set. Counting from pixel 0, line 0 begins one cycle after the control register shows run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | 32 | Register write data |
| pix_o | output | CNT_W | Current pixel position in the line |
| line_o | output | CNT_W | Current line position in the frame |
| hsync_o | output | 1 | Horizontal sync, programmed polarity |
| vsync_o | output | 1 | Vertical sync, programmed polarity |
| blank_o | output | 1 | Blanking flag |
| de_o | output | 1 | Display-enable flag |
| dac_pd_o | output | 1 | DAC power-down indication |

## Verification
The bench uses a small 8-by-6 raster and compares every output in every cycle against an arithmetic model across whole frames, first with both polarities low and then with both high. That separates off-by-one window errors from polarity inversion. It then steps through every power mode, including an unused code, and checks that each sync and the video are gated on their own. A mid-frame change with the immediate-update bit clear tells deferred application apart from immediate application. A shrinking vertical total with the bit set shows that the counters recover when they are already past the new total. Halting, restarting and a write to an unused address confirm the idle state and the start latency.

// File: rtl/rt_pkg.sv
package rt_pkg;

    localparam int FIELD_W = 16;
    localparam int WORD_W  = 2 * FIELD_W;
    localparam int NUM_TIM = 6;

    // register addresses
    localparam int A_CTRL = 0;
    localparam int A_HACT = 1;
    localparam int A_VACT = 4;

    typedef struct packed {
        logic [FIELD_W-1:0] hi;
        logic [FIELD_W-1:0] lo;
    } rt_pair_t;

    typedef struct packed {
        rt_pair_t act;
        rt_pair_t blank;
        rt_pair_t sync;
    } rt_axis_t;

    typedef struct packed {
        logic [2:0] mode;
        logic       vpol;
        logic       hpol;
        logic       now;
        logic       run;
    } rt_ctrl_t;

    typedef enum logic [2:0] {
        PM_UNBLANK = 3'd0,
        PM_BLANK   = 3'd1,
        PM_VSUSP   = 3'd2,
        PM_HSUSP   = 3'd3,
        PM_OFF     = 3'd4
    } rt_pmode_e;

    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_SCAN = 2'd1,
        ST_PEND = 2'd2
    } rt_state_e;

endpackage

// File: rtl/rt_regfile.sv
module rt_regfile
    import rt_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              load,
    output rt_ctrl_t          ctrl,
    output rt_axis_t          h_cfg,
    output rt_axis_t          v_cfg,
    output logic              tim_wr
);

    localparam int CTRL_W = $bits(rt_ctrl_t);

    rt_ctrl_t                        ctrl_q;
    logic [NUM_TIM-1:0][WORD_W-1:0]  shadow_q;
    logic [NUM_TIM-1:0][WORD_W-1:0]  work_q;
    logic [NUM_TIM-1:0]              hit;

    always_comb begin
        for (int i = 0; i < NUM_TIM; i++) begin
            hit[i] = wr_en && (wr_addr == ADDR_W'(A_HACT + i));
        end
    end

    assign tim_wr = |hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(A_CTRL)) begin
            ctrl_q <= rt_ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            work_q   <= '0;
        end else begin
            for (int i = 0; i < NUM_TIM; i++) begin
                if (hit[i]) begin
                    shadow_q[i] <= wr_data;
                end
                if (hit[i] && ctrl_q.now) begin
                    work_q[i] <= wr_data;
                end else if (load) begin
                    work_q[i] <= shadow_q[i];
                end
            end
        end
    end

    assign ctrl  = ctrl_q;
    assign h_cfg = {work_q[A_HACT-1], work_q[A_HACT], work_q[A_HACT+1]};
    assign v_cfg = {work_q[A_VACT-1], work_q[A_VACT], work_q[A_VACT+1]};

    // R10
    instant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && ctrl_q.now && wr_addr == ADDR_W'(A_HACT))
        |-> h_cfg.act == $past(wr_data));

endmodule

// File: rtl/rt_scan_cnt.sv
module rt_scan_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] htot,
    input  logic [CNT_W-1:0] vtot,
    output logic [CNT_W-1:0] pix,
    output logic [CNT_W-1:0] line,
    output logic             frame_end
);

    logic [CNT_W-1:0] pix_q;
    logic [CNT_W-1:0] line_q;
    logic             line_end;

    assign line_end  = pix_q >= htot;
    assign frame_end = run && line_end && (line_q >= vtot);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            pix_q  <= '0;
            line_q <= '0;
        end else if (line_end) begin
            pix_q  <= '0;
            line_q <= (line_q >= vtot) ? '0 : line_q + CNT_W'(1);
        end else begin
            pix_q  <= pix_q + CNT_W'(1);
        end
    end

    assign pix  = pix_q;
    assign line = line_q;

    // R2
    pix_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && pix_q >= htot |=> pix_q == '0);

    // R2
    pix_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && pix_q < htot |=> pix_q == $past(pix_q) + CNT_W'(1));

    // R2
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run && pix_q < htot |=> $stable(line_q));

endmodule

// File: rtl/rt_axis_dec.sv
module rt_axis_dec
    import rt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  rt_axis_t         cfg,
    output logic [CNT_W-1:0] total,
    output logic             in_act,
    output logic             in_blank,
    output logic             in_sync
);

    assign total    = CNT_W'(cfg.act.hi);
    assign in_act   = cnt <= CNT_W'(cfg.act.lo);
    assign in_blank = (cnt > CNT_W'(cfg.blank.lo)) && (cnt <= CNT_W'(cfg.blank.hi));
    assign in_sync  = (cnt > CNT_W'(cfg.sync.lo)) && (cnt <= CNT_W'(cfg.sync.hi));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic [CNT_W-1:0]  pix_o,
    output logic [CNT_W-1:0]  line_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              blank_o,
    output logic              de_o,
    output logic              dac_pd_o
);

    localparam int N_AXIS = 2;

    rt_state_e  state_q, state_d;
    rt_ctrl_t   ctrl;
    rt_axis_t   h_cfg, v_cfg;
    logic       tim_wr, load, frame_end, scanning, deferred;
    logic [CNT_W-1:0]             pix, line;
    logic [N_AXIS-1:0][CNT_W-1:0] tot;
    logic [N_AXIS-1:0]            in_act, in_blank, in_sync;
    logic       vid_on, hs_en, vs_en, hs_act, vs_act;

    rt_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .load    (load),
        .ctrl    (ctrl),
        .h_cfg   (h_cfg),
        .v_cfg   (v_cfg),
        .tim_wr  (tim_wr)
    );

    rt_scan_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (scanning),
        .htot      (tot[0]),
        .vtot      (tot[1]),
        .pix       (pix),
        .line      (line),
        .frame_end (frame_end)
    );

    for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
        rt_axis_dec #(.CNT_W(CNT_W)) u_dec (
            .cnt      ((a == 0) ? pix : line),
            .cfg      ((a == 0) ? h_cfg : v_cfg),
            .total    (tot[a]),
            .in_act   (in_act[a]),
            .in_blank (in_blank[a]),
            .in_sync  (in_sync[a])
        );
    end

    assign scanning = (state_q != ST_HALT);
    assign deferred = tim_wr && !ctrl.now;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and copy strobe
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        unique case (state_q)
            ST_HALT: begin
                if (ctrl.run) begin
                    state_d = ST_SCAN;
                    load    = 1'b1;
                end
            end
            ST_SCAN: begin
                if (!ctrl.run) begin
                    state_d = ST_HALT;
                end else if (deferred) begin
                    state_d = ST_PEND;
                end
            end
            ST_PEND: begin
                if (!ctrl.run) begin
                    state_d = ST_HALT;
                end else if (frame_end) begin
                    load    = 1'b1;
                    state_d = deferred ? ST_PEND : ST_SCAN;
                end
            end
            default: state_d = ST_HALT;
        endcase
    end

    // outputs
    always_comb begin
        unique case (ctrl.mode)
            PM_UNBLANK: begin vid_on = 1'b1; hs_en = 1'b1; vs_en = 1'b1; end
            PM_BLANK:   begin vid_on = 1'b0; hs_en = 1'b1; vs_en = 1'b1; end
            PM_VSUSP:   begin vid_on = 1'b0; hs_en = 1'b1; vs_en = 1'b0; end
            PM_HSUSP:   begin vid_on = 1'b0; hs_en = 1'b0; vs_en = 1'b1; end
            default:    begin vid_on = 1'b0; hs_en = 1'b0; vs_en = 1'b0; end
        endcase
        hs_act   = scanning && hs_en && in_sync[0];
        vs_act   = scanning && vs_en && in_sync[1];
        hsync_o  = ctrl.hpol ? hs_act : !hs_act;
        vsync_o  = ctrl.vpol ? vs_act : !vs_act;
        blank_o  = !scanning || !vid_on || in_blank[0] || in_blank[1];
        de_o     = scanning && vid_on && in_act[0] && in_act[1];
        dac_pd_o = !(hs_en && vs_en);
        pix_o    = pix;
        line_o   = line;
    end

    // R8
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HALT && $past(state_q == ST_HALT)
        |-> pix_o == '0 && line_o == '0);

    // R8
    halt_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_HALT |-> blank_o && !de_o);

    // R9
    load_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (state_q == ST_HALT) || frame_end);

    // R6
    off_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.mode >= 3'(PM_OFF)
        |-> hsync_o != ctrl.hpol && vsync_o != ctrl.vpol && dac_pd_o);

    // R7
    dac_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_pd_o && scanning && in_sync[0] |-> hsync_o == ctrl.hpol);

endmodule

// File: tb/raster_timing_gen_bench.sv
module raster_timing_gen_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [15:0] pix_o, line_o;
    logic        hsync_o, vsync_o, blank_o, de_o, dac_pd_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference model state
    int          m_pix, m_line;
    bit          m_scan, m_pend;
    logic [6:0]  m_ctrl;
    logic [31:0] m_sh [1:6];
    logic [31:0] m_ac [1:6];

    always #(CLK_PERIOD/2) clk = ~clk;

    raster_timing_gen u_raster_timing_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pix_o    (pix_o),
        .line_o   (line_o),
        .hsync_o  (hsync_o),
        .vsync_o  (vsync_o),
        .blank_o  (blank_o),
        .de_o     (de_o),
        .dac_pd_o (dac_pd_o)
    );

    function automatic logic [31:0] pk(int hi, int lo);
        return {16'(hi - 1), 16'(lo - 1)};
    endfunction

    function automatic int fld(int r, bit upper);
        return upper ? int'(m_ac[r][31:16]) : int'(m_ac[r][15:0]);
    endfunction

    task automatic chk(string req, string phase, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (%s) at pix=%0d line=%0d: actual=%0d expected=%0d",
                     req, phase, m_pix, m_line, act, exp);
        end
    endtask

    task automatic compare(string phase);
        int  mode;
        bit  vid_on, hs_en, vs_en, hsa, vsa, e_de, e_blank;
        mode   = int'(m_ctrl[6:4]);
        vid_on = (mode == 0);
        hs_en  = (mode <= 2);
        vs_en  = (mode <= 1) || (mode == 3);
        e_de   = m_scan && vid_on && m_pix <= fld(1, 0) && m_line <= fld(4, 0);
        e_blank = !m_scan || !vid_on
                  || (m_pix > fld(2, 0) && m_pix <= fld(2, 1))
                  || (m_line > fld(5, 0) && m_line <= fld(5, 1));
        hsa = m_scan && hs_en && m_pix > fld(3, 0) && m_pix <= fld(3, 1);
        vsa = m_scan && vs_en && m_line > fld(6, 0) && m_line <= fld(6, 1);
        chk("R2 pixel", phase, int'(pix_o), m_pix);
        chk("R2 line", phase, int'(line_o), m_line);
        chk("R3 de", phase, int'(de_o), int'(e_de));
        chk("R4 blank", phase, int'(blank_o), int'(e_blank));
        chk("R5 hsync", phase, int'(hsync_o), int'(m_ctrl[2] ? hsa : !hsa));
        chk("R5 vsync", phase, int'(vsync_o), int'(m_ctrl[3] ? vsa : !vsa));
        chk("R7 dac_pd", phase, int'(dac_pd_o), int'(!(hs_en && vs_en)));
    endtask

    task automatic advance(bit we, int addr, logic [31:0] data);
        bit run, now, fe, tw, load;
        int htot, vtot;
        run  = m_ctrl[0];
        now  = m_ctrl[1];
        htot = fld(1, 1);
        vtot = fld(4, 1);
        fe   = m_scan && m_pix >= htot && m_line >= vtot;
        tw   = we && addr >= 1 && addr <= 6;
        load = (!m_scan && run) || (m_pend && fe);
        if (!m_scan) begin
            m_pix = 0; m_line = 0;
        end else if (m_pix >= htot) begin
            m_pix  = 0;
            m_line = (m_line >= vtot) ? 0 : m_line + 1;
        end else begin
            m_pix = m_pix + 1;
        end
        if (load) for (int r = 1; r <= 6; r++) m_ac[r] = m_sh[r];
        if (tw && now) m_ac[addr] = data;
        if (tw) m_sh[addr] = data;
        if (!m_scan) begin
            m_scan = run; m_pend = 1'b0;
        end else if (!run) begin
            m_scan = 1'b0; m_pend = 1'b0;
        end else if (m_pend) begin
            m_pend = fe ? (tw && !now) : 1'b1;
        end else begin
            m_pend = tw && !now;
        end
        if (we && addr == 0) m_ctrl = data[6:0];
    endtask

    task automatic cyc(bit we, int addr, logic [31:0] data, string phase);
        @(negedge clk);
        compare(phase);
        wr_en   = we;
        wr_addr = 4'(addr);
        wr_data = data;
        advance(we, addr, data);
    endtask

    task automatic wr(int addr, logic [31:0] data, string phase);
        cyc(1'b1, addr, data, phase);
    endtask

    task automatic idle(int n, string phase);
        for (int i = 0; i < n; i++) cyc(1'b0, 0, 32'h0, phase);
    endtask

    initial begin
        m_pix = 0; m_line = 0; m_scan = 0; m_pend = 0; m_ctrl = '0;
        for (int r = 1; r <= 6; r++) begin m_sh[r] = '0; m_ac[r] = '0; end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        idle(3, "R8 reset state");

        // R1 program 8x6 raster while halted
        wr(1, pk(8, 4), "R1 program");
        wr(2, pk(8, 4), "R1 program");
        wr(3, pk(7, 5), "R1 program");
        wr(4, pk(6, 3), "R1 program");
        wr(5, pk(6, 3), "R1 program");
        wr(6, pk(5, 4), "R1 program");
        idle(2, "R11 halted before start");
        wr(0, 32'h01, "R11 start");
        idle(100, "R2 frame sweep");

        wr(0, 32'h0D, "R5 polarity high");
        idle(50, "R5 polarity high");

        for (int m = 1; m <= 7; m++) begin
            if (m == 5 || m == 6) continue;
            wr(0, {25'd0, 3'(m), 4'b0001}, "R6 mode");
            idle(50, "R6 mode");
        end

        wr(0, 32'h01, "R9 setup");
        idle(10, "R9 setup");
        wr(1, pk(10, 5), "R9 deferred");
        wr(2, pk(10, 5), "R9 deferred");
        idle(7, "R9 deferred");
        wr(3, pk(9, 6), "R9 deferred");
        idle(130, "R9 deferred");

        wr(0, 32'h03, "R10 setup");
        idle(25, "R10 setup");
        wr(4, pk(4, 2), "R10 instant");
        wr(5, pk(4, 2), "R10 instant");
        wr(6, pk(4, 3), "R10 instant");
        idle(90, "R10 instant");

        wr(7, 32'hFFFF_FFFF, "R1 unused address");
        wr(12, 32'h0000_0000, "R1 unused address");
        idle(45, "R1 unused address");

        wr(0, 32'h00, "R8 halt");
        idle(20, "R8 halt");
        wr(0, 32'h01, "R11 restart");
        idle(40, "R11 restart");

        @(negedge clk);
        compare("final");
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule